// File: doc/BRIEF.md
# Serial Byte Pattern Loader

This block holds a column of test pattern data for a memory device that is being prepared for receive timing calibration. Pattern data arrives one byte at a time. Each byte shifts a column-wide holding register by eight bit positions. The new byte always enters at the least-significant end. A byte counter reports when a whole column has been delivered. This one shift path fills the column for any device width.

After the column is loaded, write commands drain it to a core write port. Each write command carries a 4-bit sub-column index. A programmed-width setting decides how many sub-columns the column holds and how wide each one is. The selected slice goes out on the core data bus with a single-cycle write strobe. Framing of the serial channel and the memory array are outside this block.

Top module: `pattern_loader`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, `core_we` is 0, `core_data` is all zeros and `col_full` is 0.
- R2: Each cycle with `byte_vld` high shifts the holding register left by 8 bits, and `byte_dat` enters bits [7:0].
- R3: `col_full` rises the cycle after the NATIVE_W/8-th byte (8 with the default width) and then stays high. Later bytes keep shifting, and the oldest byte is lost from the top.
- R4: With `width_sel` = w, the column splits into 2^w sub-columns, each NATIVE_W >> w bits wide (for the default: 0 gives one of 64, 1 gives two of 32, 2 gives four of 16, 3 gives eight of 8).
- R5: Sub-column index k selects holding bits [k*SW +: SW], so index 0 is the least-significant slice. The slice is zero-extended onto `core_data`.
- R6: A write command that is accepted on a clock edge gives `core_we` high for exactly the following cycle. The selected slice is on `core_data` in that same cycle.
- R7: A write command sampled while `col_full` is 0 produces no core write. This includes the edge at which the completing byte arrives.
- R8: A write command whose index is not below 2^`width_sel` produces no core write.
- R9: When a byte and a write command are sampled on the same edge, the write takes its slice from the column as it was before that byte shifted in.
- R10: `core_data` keeps the last written slice while `core_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_vld | input | 1 | Pattern byte present this cycle |
| byte_dat | input | 8 | Pattern byte |
| wr_cmd | input | 1 | Write command for one sub-column |
| wr_sc | input | 4 | Sub-column index of the write command |
| width_sel | input | 2 | Programmed width: sub-column width is NATIVE_W >> width_sel |
| col_full | output | 1 | A full column of bytes has been received |
| core_we | output | 1 | Single-cycle core write strobe |
| core_data | output | 64 | Selected sub-column, zero-extended |

## Verification
A byte shift and a write command can be sampled on the same edge. The bench provokes this twice. First it sends the byte that completes the column together with a command; no core write may follow, because the column was not yet full. Later it sends a byte into an already full column together with a command for sub-column 0. The strobe must then carry the byte that was lowest before the shift. A follow-up command must show the new byte in that position.

// File: rtl/pl_pkg.sv
package pl_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SC_W   = 4;

  // Write request after qualification, handed to the core port.
  typedef struct packed {
    logic           fire;
    logic [SC_W-1:0] idx;
  } pl_wr_req_t;

  function automatic int unsigned pl_bytes_per_col(input int unsigned col_w);
    return col_w / BYTE_W;
  endfunction

endpackage

// File: rtl/pl_shift_hold.sv
module pl_shift_hold
  import pl_pkg::*;
#(
  parameter int unsigned NATIVE_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_vld,
  input  logic [BYTE_W-1:0]   byte_dat,
  output logic [NATIVE_W-1:0] hold_q,
  output logic                full_q
);

  localparam int unsigned BYTES = pl_bytes_per_col(NATIVE_W);
  localparam int unsigned CNT_W = $clog2(BYTES + 1);

  logic [NATIVE_W-1:0] hold_d;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_d;
  logic                hold_en;
  logic                cnt_en;

  assign full_q  = (cnt_q == CNT_W'(BYTES));
  assign hold_en = byte_vld;
  assign cnt_en  = byte_vld & ~full_q;

  always_comb begin
    hold_d = {hold_q[NATIVE_W-BYTE_W-1:0], byte_dat};
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pl_slice_sel.sv
module pl_slice_sel
  import pl_pkg::*;
#(
  parameter int unsigned NATIVE_W = 64,
  parameter int unsigned WSEL_W   = 2
) (
  input  logic [NATIVE_W-1:0] hold,
  input  logic [WSEL_W-1:0]   width_sel,
  input  logic [SC_W-1:0]     idx,
  output logic                hit,
  output logic [NATIVE_W-1:0] slice
);

  localparam int unsigned NUM_MODES = 1 << WSEL_W;

  logic [NUM_MODES-1:0]               mode_hit;
  logic [NUM_MODES-1:0][NATIVE_W-1:0] mode_data;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int unsigned SW  = NATIVE_W >> m;
    localparam int unsigned CNT = 1 << m;

    logic                hit_m;
    logic [NATIVE_W-1:0] data_m;

    always_comb begin
      hit_m  = 1'b0;
      data_m = '0;
      for (int k = 0; k < CNT; k++) begin
        if (idx == SC_W'(k)) begin
          hit_m  = 1'b1;
          data_m = NATIVE_W'(hold[k*SW +: SW]);
        end
      end
    end

    assign mode_hit[m]  = hit_m;
    assign mode_data[m] = data_m;
  end

  assign hit   = mode_hit[width_sel];
  assign slice = mode_data[width_sel];

endmodule

// File: rtl/pl_core_port.sv
module pl_core_port
  import pl_pkg::*;
#(
  parameter int unsigned NATIVE_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pl_wr_req_t          req,
  input  logic [NATIVE_W-1:0] slice,
  output logic                core_we,
  output logic [NATIVE_W-1:0] core_data
);

  logic                we_d;
  logic [NATIVE_W-1:0] data_d;
  logic                data_en;

  assign data_en = req.fire;

  always_comb begin
    we_d   = req.fire;
    data_d = slice;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_we <= 1'b0;
    end else begin
      core_we <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_data <= '0;
    end else if (data_en) begin
      core_data <= data_d;
    end
  end

endmodule

// File: rtl/pattern_loader.sv
module pattern_loader
  import pl_pkg::*;
#(
  parameter int unsigned NATIVE_W = 64,
  parameter int unsigned WSEL_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_vld,
  input  logic [7:0]          byte_dat,
  input  logic                wr_cmd,
  input  logic [3:0]          wr_sc,
  input  logic [WSEL_W-1:0]   width_sel,
  output logic                col_full,
  output logic                core_we,
  output logic [NATIVE_W-1:0] core_data
);

  logic [1:0]          rst_sync_q;
  logic                rst_sync_n;
  logic [NATIVE_W-1:0] hold_q;
  logic                full_q;
  logic                sel_hit;
  logic [NATIVE_W-1:0] sel_slice;
  pl_wr_req_t          wr_req;

  // Asynchronous assertion, release aligned to clk.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  pl_shift_hold #(.NATIVE_W(NATIVE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat),
    .hold_q   (hold_q),
    .full_q   (full_q)
  );

  pl_slice_sel #(.NATIVE_W(NATIVE_W), .WSEL_W(WSEL_W)) u_sel (
    .hold      (hold_q),
    .width_sel (width_sel),
    .idx       (wr_sc),
    .hit       (sel_hit),
    .slice     (sel_slice)
  );

  // The slice comes from the pre-shift column, so a same-edge byte is not seen.
  always_comb begin
    wr_req.fire = wr_cmd & full_q & sel_hit;
    wr_req.idx  = wr_sc;
  end

  pl_core_port #(.NATIVE_W(NATIVE_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (wr_req),
    .slice     (sel_slice),
    .core_we   (core_we),
    .core_data (core_data)
  );

  assign col_full = full_q;

endmodule

// File: rtl/pattern_loader_chk.sv
module pattern_loader_chk #(
  parameter int unsigned NATIVE_W = 64,
  parameter int unsigned WSEL_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                byte_vld,
  input logic [7:0]          byte_dat,
  input logic                wr_cmd,
  input logic [3:0]          wr_sc,
  input logic [WSEL_W-1:0]   width_sel,
  input logic                col_full,
  input logic                core_we,
  input logic [NATIVE_W-1:0] core_data,
  input logic [NATIVE_W-1:0] hold
);

  a_r2_byte_enters_low: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> hold[7:0] == $past(byte_dat));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(hold));

  a_r3_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    col_full |=> col_full);

  a_r6_we_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> $past(wr_cmd));

  a_r7_no_write_unfull: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> $past(col_full));

  a_r8_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> (int'($past(wr_sc)) < (1 << $past(width_sel))));

  a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !core_we |-> $stable(core_data));

endmodule

bind pattern_loader pattern_loader_chk #(.NATIVE_W(NATIVE_W), .WSEL_W(WSEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .byte_vld  (byte_vld),
  .byte_dat  (byte_dat),
  .wr_cmd    (wr_cmd),
  .wr_sc     (wr_sc),
  .width_sel (width_sel),
  .col_full  (col_full),
  .core_we   (core_we),
  .core_data (core_data),
  .hold      (hold_q)
);

// File: tb/pattern_loader_test.sv
module pattern_loader_test;

  logic        clk;
  logic        rst_n;
  logic        byte_vld;
  logic [7:0]  byte_dat;
  logic        wr_cmd;
  logic [3:0]  wr_sc;
  logic [1:0]  width_sel;
  logic        col_full;
  logic        core_we;
  logic [63:0] core_data;

  int checks;
  int failures;
  int cycles;
  logic [63:0] last_data;

  pattern_loader uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_dat  (byte_dat),
    .wr_cmd    (wr_cmd),
    .wr_sc     (wr_sc),
    .width_sel (width_sel),
    .col_full  (col_full),
    .core_we   (core_we),
    .core_data (core_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Column after bytes A0..A7: A0 at the top, A7 in bits [7:0].
  localparam int NV = 12;
  localparam logic [1:0]  V_WS [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd2,
                                        2'd2, 2'd3, 2'd3, 2'd3, 2'd3, 2'd2};
  localparam logic [3:0]  V_SC [NV] = '{4'd0, 4'd1, 4'd0, 4'd1, 4'd2, 4'd0,
                                        4'd3, 4'd0, 4'd5, 4'd7, 4'd8, 4'd15};
  localparam logic        V_WE [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                                        1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [63:0] V_DT [NV] = '{64'hA0A1A2A3A4A5A6A7, 64'h0,
                                        64'hA4A5A6A7, 64'hA0A1A2A3, 64'h0,
                                        64'hA6A7, 64'hA0A1, 64'hA7, 64'hA2,
                                        64'hA0, 64'h0, 64'h0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and returns at the next falling edge.
  task automatic step(input logic bv, input logic [7:0] bd, input logic wc,
                      input logic [1:0] ws, input logic [3:0] sc);
    byte_vld  = bv;
    byte_dat  = bd;
    wr_cmd    = wc;
    width_sel = ws;
    wr_sc     = sc;
    @(negedge clk);
    byte_vld = 1'b0;
    wr_cmd   = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    checks = 0; failures = 0; cycles = 0;
    rst_n = 1'b0; byte_vld = 1'b0; byte_dat = '0; wr_cmd = 1'b0;
    wr_sc = '0; width_sel = '0;
    repeat (3) @(negedge clk);
    check("R1 we in reset", 64'(core_we), 64'd0);
    check("R1 full in reset", 64'(col_full), 64'd0);
    check("R1 data in reset", core_data, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 we after release", 64'(core_we), 64'd0);

    // Seven bytes: column not full yet.
    for (int i = 0; i < 7; i++) step(1'b1, 8'hA0 + 8'(i), 1'b0, 2'd0, 4'd0);
    check("R3 not full after 7", 64'(col_full), 64'd0);
    step(1'b0, 8'h0, 1'b1, 2'd3, 4'd0);
    check("R7 no write while unfull", 64'(core_we), 64'd0);
    // Completing byte with a command on the same edge.
    step(1'b1, 8'hA7, 1'b1, 2'd3, 4'd0);
    check("R7 R9 no write on completing edge", 64'(core_we), 64'd0);
    check("R3 full after 8", 64'(col_full), 64'd1);
    check("R1 data untouched", core_data, 64'd0);

    last_data = 64'h0;
    for (int v = 0; v < NV; v++) begin
      step(1'b0, 8'h0, 1'b1, V_WS[v], V_SC[v]);
      check("R6 R8 strobe", 64'(core_we), 64'(V_WE[v]));
      if (V_WE[v]) last_data = V_DT[v];
      check("R4 R5 R10 data", core_data, last_data);
      @(negedge clk);
      check("R6 single pulse", 64'(core_we), 64'd0);
      check("R10 data held", core_data, last_data);
    end

    // Ninth byte: shifts in low, oldest dropped.
    step(1'b1, 8'hB8, 1'b0, 2'd0, 4'd0);
    check("R3 still full", 64'(col_full), 64'd1);
    step(1'b0, 8'h0, 1'b1, 2'd3, 4'd0);
    check("R2 new byte low", core_data, 64'hB8);
    step(1'b0, 8'h0, 1'b1, 2'd3, 4'd7);
    check("R3 oldest dropped", core_data, 64'hA1);
    step(1'b0, 8'h0, 1'b1, 2'd0, 4'd0);
    check("R2 whole column", core_data, 64'hA1A2A3A4A5A6A7B8);

    // Byte and command on the same edge: pre-shift column.
    step(1'b1, 8'hC9, 1'b1, 2'd3, 4'd0);
    check("R9 same-edge strobe", 64'(core_we), 64'd1);
    check("R9 same-edge data", core_data, 64'hB8);
    step(1'b0, 8'h0, 1'b1, 2'd2, 4'd0);
    check("R9 R2 after shift", core_data, 64'hB8C9);

    // Reset mid-run.
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 full cleared", 64'(col_full), 64'd0);
    check("R1 data cleared", core_data, 64'd0);
    check("R1 we cleared", 64'(core_we), 64'd0);
    finish_run();
  end

endmodule